// File: doc/BRIEF.md
# Bank Controller with Latched Real-Time Clock

This block sits between a CPU's write bus and a banked cartridge memory. Writes are sorted into eight regions by address bits [15:13]. Four of these regions act as control registers. They set the switchable ROM bank and open or close the external RAM window. They also choose what the window shows: one of the external RAM banks, or one of the five clock registers. The RAM array itself lies outside this block. The block drives the bank number and a select line for it.

A running clock counts seconds, minutes, hours and a 9-bit day count, and advances once for each pulse on a one-second tick input. Software never reads the running counters directly. It first writes 0 and then 1 to the latch region, which copies all five counters into a snapshot. Window reads then return the selected snapshot register. While the window shows the clock, a write to region 5 sets the selected running counter, when the option for register writes is on. Such a write is also the only way, apart from reset, to clear the sticky day-overflow flag.

Top module: `rtc_bank_ctrl`

## Requirements
- R1: Writing 0x0A to region 0 sets `ram_en`, and writing 0x00 clears it. Any other value leaves it unchanged. Writes to other regions never change it.
- R2: A write to region 1 sets `rom_bank` to `wr_data[6:0]`, with the value 0 replaced by 1. Bit 7 is ignored.
- R3: In region 2, the values 0 to 3 set `ram_bank` and clear `rtc_sel`. The values 8 to 12 select clock register (value − 8) and set `rtc_sel`. All other values change nothing.
- R4: A write of 1 to region 3 while unlatched copies the running counters into the snapshot in that cycle and marks the clock latched. A write of 0 while latched clears the mark. All other region 3 writes do nothing, including a second write of 1 while latched.
- R5: The snapshot, and so the read data, does not change with clock ticks. It changes only at the next latch.
- R6: Each tick advances seconds. Seconds wrap from 59 to 0 and minutes from 59 to 0, each carrying onward. Hours wrap from 23 to 0 and carry into the day count.
- R7: Register 0 reads seconds, register 1 minutes and register 2 hours, each zero-extended. Register 3 reads day bits [7:0]. Register 4 reads day bit 8 in bit 0 and the carry flag in bit 7, with bits 6:1 reading 0.
- R8: When the day count wraps from 511 to 0, the carry flag is set and stays set through further ticks. Only reset, or a region-5 write to register 4 with bit 7 clear, clears it.
- R9: `win_rd_data` is 0xFF whenever `ram_en` is 0 or `rtc_sel` is 0. Otherwise it is the selected snapshot register. `ram_sel` is `ram_en` with `rtc_sel` clear.
- R10: A region-5 write while `ram_en` and `rtc_sel` are both set loads the selected running register. Register 3 loads day bits [7:0]; register 4 loads day bit 8 from bit 0 and the carry flag from bit 7. Such a write wins over a tick in the same cycle, and that tick is dropped. A region-5 write with `rtc_sel` clear leaves the counters unchanged.
- R11: After reset the following hold: `rom_bank` 1, `ram_bank` 0, `ram_en` 0, `rtc_sel` 0, all counters and the snapshot 0, and the clock unlatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address; bits [15:13] pick the region |
| wr_data | input | 8 | CPU write data |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| rom_bank | output | ROM_BANK_W (7) | Switchable ROM bank, never 0 |
| ram_bank | output | RAM_BANK_W (2) | External RAM bank |
| ram_en | output | 1 | Window enabled |
| ram_sel | output | 1 | Window routed to external RAM |
| rtc_sel | output | 1 | Window routed to clock registers |
| win_rd_data | output | 8 | Clock register read data, 0xFF when not selected |

## Verification
The bench builds the block with its default parameters: a 7-bit ROM bank, a 2-bit RAM bank and clock register writes on. With these, every value of the three control regions can be swept exhaustively. The write option lets the bench preset the clock to 511 days 23:59:59, so the day overflow and its sticky flag are reached in one tick rather than after 44 million. A tick run of just over one simulated day (90,099 ticks) covers every carry chain up through the day count, checked against an arithmetic model at eight latch points.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;

   localparam int NUM_REGIONS = 8;

   localparam logic [2:0] RG_ENABLE = 3'd0;
   localparam logic [2:0] RG_ROM    = 3'd1;
   localparam logic [2:0] RG_SELECT = 3'd2;
   localparam logic [2:0] RG_LATCH  = 3'd3;
   localparam logic [2:0] RG_WINDOW = 3'd5;

   localparam logic [7:0] KEY_ON  = 8'h0A;
   localparam logic [7:0] KEY_OFF = 8'h00;

   localparam logic [7:0] CLK_SEL_FIRST = 8'd8;
   localparam logic [7:0] CLK_SEL_LAST  = 8'd12;

   typedef struct packed {
      logic       carry;
      logic [8:0] day;
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } rtc_time_t;

   function automatic logic [7:0] clk_reg_view(rtc_time_t t, logic [2:0] sel);
      logic [7:0] v;
      case (sel)
         3'd0:    v = {2'b00, t.sec};
         3'd1:    v = {2'b00, t.min};
         3'd2:    v = {3'b000, t.hour};
         3'd3:    v = t.day[7:0];
         3'd4:    v = {t.carry, 6'b000000, t.day[8]};
         default: v = 8'hFF;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
   parameter int W     = 6,
   parameter int LIMIT = 60
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q,
   output logic         wrap
);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   initial begin
      if (LIMIT < 2 || LIMIT > (1 << W))
         $error("rtc_wrap_cnt: LIMIT out of range for W");
   end

   assign wrap = inc && (q >= LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (ld)   q <= ld_val;
      else if (wrap) q <= '0;
      else if (inc)  q <= q + W'(1);
   end
endmodule

// File: rtl/rtc_bank_decode.sv
module rtc_bank_decode
   import rtc_bank_pkg::*;
#(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_REGIONS-1:0] rg_stb,
   input  logic [7:0]             wr_data,
   output logic                   ram_en_q,
   output logic [ROM_BANK_W-1:0]  rom_bank_q,
   output logic [RAM_BANK_W-1:0]  ram_bank_q,
   output logic                   rtc_acc_q,
   output logic [2:0]             reg_sel_q
);
   logic [ROM_BANK_W-1:0] rom_req;
   logic                  sel_ram, sel_clk;

   assign rom_req = wr_data[ROM_BANK_W-1:0];
   assign sel_ram = wr_data < 8'd4;
   assign sel_clk = (wr_data >= CLK_SEL_FIRST) && (wr_data <= CLK_SEL_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_en_q   <= 1'b0;
         rom_bank_q <= ROM_BANK_W'(1);
         ram_bank_q <= '0;
         rtc_acc_q  <= 1'b0;
         reg_sel_q  <= 3'd0;
      end else begin
         if (rg_stb[RG_ENABLE]) begin
            if (wr_data == KEY_ON)       ram_en_q <= 1'b1;
            else if (wr_data == KEY_OFF) ram_en_q <= 1'b0;
         end
         if (rg_stb[RG_ROM])
            rom_bank_q <= (rom_req == '0) ? ROM_BANK_W'(1) : rom_req;
         if (rg_stb[RG_SELECT]) begin
            if (sel_ram) begin
               ram_bank_q <= wr_data[RAM_BANK_W-1:0];
               rtc_acc_q  <= 1'b0;
            end else if (sel_clk) begin
               reg_sel_q <= 3'(wr_data - CLK_SEL_FIRST);
               rtc_acc_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
   import rtc_bank_pkg::*;
#(
   parameter bit CPU_WR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       wr_stb,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   output rtc_time_t  now
);
   logic       wr_go, step;
   logic       s_wrap, m_wrap, h_wrap, d_wrap;
   logic [5:0] sec_q, min_q;
   logic [4:0] hour_q;
   logic [8:0] day_q, day_ld;
   logic       carry_q;

   generate
      if (CPU_WR) begin : g_cpu_wr
         assign wr_go = wr_stb;
      end else begin : g_no_cpu_wr
         assign wr_go = 1'b0;
      end
   endgenerate

   assign step   = tick && !wr_go;
   assign day_ld = (wr_sel == 3'd3) ? {day_q[8], wr_data} : {wr_data[0], day_q[7:0]};

   rtc_wrap_cnt #(.W(6), .LIMIT(60)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(step), .ld(wr_go && wr_sel == 3'd0),
      .ld_val(wr_data[5:0]), .q(sec_q), .wrap(s_wrap));

   rtc_wrap_cnt #(.W(6), .LIMIT(60)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(s_wrap), .ld(wr_go && wr_sel == 3'd1),
      .ld_val(wr_data[5:0]), .q(min_q), .wrap(m_wrap));

   rtc_wrap_cnt #(.W(5), .LIMIT(24)) u_hour (
      .clk(clk), .rst_n(rst_n), .inc(m_wrap), .ld(wr_go && wr_sel == 3'd2),
      .ld_val(wr_data[4:0]), .q(hour_q), .wrap(h_wrap));

   rtc_wrap_cnt #(.W(9), .LIMIT(512)) u_day (
      .clk(clk), .rst_n(rst_n), .inc(h_wrap),
      .ld(wr_go && (wr_sel == 3'd3 || wr_sel == 3'd4)),
      .ld_val(day_ld), .q(day_q), .wrap(d_wrap));

   always_ff @(posedge clk) begin
      if (!rst_n)                          carry_q <= 1'b0;
      else if (wr_go && wr_sel == 3'd4)    carry_q <= wr_data[7];
      else if (d_wrap)                     carry_q <= 1'b1;
   end

   always_comb begin
      now.sec   = sec_q;
      now.min   = min_q;
      now.hour  = hour_q;
      now.day   = day_q;
      now.carry = carry_q;
   end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
   import rtc_bank_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      latch_stb,
   input  logic [7:0] wr_data,
   input  rtc_time_t now,
   output rtc_time_t snap,
   output logic      latched
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap    <= '0;
         latched <= 1'b0;
      end else if (latch_stb) begin
         if (!latched && wr_data == 8'd1) begin
            snap    <= now;
            latched <= 1'b1;
         end else if (latched && wr_data == 8'd0) begin
            latched <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rtc_bank_ctrl.sv
module rtc_bank_ctrl
   import rtc_bank_pkg::*;
#(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2,
   parameter bit CPU_WR     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [15:0]           wr_addr,
   input  logic [7:0]            wr_data,
   input  logic                  sec_tick,
   output logic [ROM_BANK_W-1:0] rom_bank,
   output logic [RAM_BANK_W-1:0] ram_bank,
   output logic                  ram_en,
   output logic                  ram_sel,
   output logic                  rtc_sel,
   output logic [7:0]            win_rd_data
);
   initial begin
      if (ROM_BANK_W < 1 || ROM_BANK_W > 8) $error("rtc_bank_ctrl: ROM_BANK_W must be 1..8");
      if (RAM_BANK_W < 1 || RAM_BANK_W > 2) $error("rtc_bank_ctrl: RAM_BANK_W must be 1..2");
   end

   logic [NUM_REGIONS-1:0] rg_stb;
   logic [2:0]             reg_sel;
   logic                   latched_q;
   rtc_time_t              t_now, t_snap;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_stb
      assign rg_stb[g] = wr_en && (wr_addr[15:13] == 3'(g));
   end

   rtc_bank_decode #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .rg_stb(rg_stb), .wr_data(wr_data),
      .ram_en_q(ram_en), .rom_bank_q(rom_bank), .ram_bank_q(ram_bank),
      .rtc_acc_q(rtc_sel), .reg_sel_q(reg_sel));

   rtc_time_core #(.CPU_WR(CPU_WR)) u_time (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick),
      .wr_stb(rg_stb[RG_WINDOW] && ram_en && rtc_sel),
      .wr_sel(reg_sel), .wr_data(wr_data), .now(t_now));

   rtc_snapshot u_snap (
      .clk(clk), .rst_n(rst_n), .latch_stb(rg_stb[RG_LATCH]), .wr_data(wr_data),
      .now(t_now), .snap(t_snap), .latched(latched_q));

   assign ram_sel     = ram_en && !rtc_sel;
   assign win_rd_data = (ram_en && rtc_sel) ? clk_reg_view(t_snap, reg_sel) : 8'hFF;
endmodule

// File: rtl/rtc_bank_chk.sv
module rtc_bank_chk #(
   parameter int ROM_BANK_W = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [15:0]           wr_addr,
   input logic [7:0]            wr_data,
   input logic [ROM_BANK_W-1:0] rom_bank,
   input logic                  ram_en,
   input logic                  win_rd_data_ff,
   input logic [7:0]            win_rd_data,
   input logic                  latched,
   input logic                  carry
);
   assert_en_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:13] != 3'd0) |=> $stable(ram_en));

   assert_rom_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rom_bank != '0);

   assert_latch_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:13] == 3'd3 && wr_data == 8'd1) |=> latched);

   assert_snap_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(win_rd_data));

   assert_carry_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (carry && !(wr_en && wr_addr[15:13] == 3'd5)) |=> carry);

   assert_closed_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_en |-> win_rd_data_ff);
endmodule

bind rtc_bank_ctrl rtc_bank_chk #(.ROM_BANK_W(ROM_BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rom_bank(rom_bank), .ram_en(ram_en), .win_rd_data_ff(win_rd_data == 8'hFF),
   .win_rd_data(win_rd_data), .latched(latched_q), .carry(t_now.carry));

// File: tb/tb_rtc_bank_ctrl.sv
module tb_rtc_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = 16'h0;
   logic [7:0]  wr_data = 8'h0;
   logic        sec_tick = 1'b0;
   logic [6:0]  rom_bank;
   logic [1:0]  ram_bank;
   logic        ram_en, ram_sel, rtc_sel;
   logic [7:0]  win_rd_data;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int m_s = 0, m_m = 0, m_h = 0, m_d = 0, m_c = 0;

   always #4 clk = ~clk;

   rtc_bank_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sec_tick(sec_tick), .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en),
      .ram_sel(ram_sel), .rtc_sel(rtc_sel), .win_rd_data(win_rd_data));

   task automatic check(string rq, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
      end
   endtask

   task automatic cpu_wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(int n);
      @(negedge clk);
      sec_tick = 1'b1;
      repeat (n) @(negedge clk);
      sec_tick = 1'b0;
   endtask

   function automatic void model_adv();
      m_s++;
      if (m_s == 60) begin
         m_s = 0; m_m++;
         if (m_m == 60) begin
            m_m = 0; m_h++;
            if (m_h == 24) begin
               m_h = 0; m_d++;
               if (m_d == 512) begin m_d = 0; m_c = 1; end
            end
         end
      end
   endfunction

   task automatic run_ticks(int n);
      ticks(n);
      for (int i = 0; i < n; i++) model_adv();
   endtask

   task automatic do_latch();
      cpu_wr(16'h6000, 8'h00);
      cpu_wr(16'h6000, 8'h01);
   endtask

   task automatic rd_reg(int sel, output logic [7:0] v);
      cpu_wr(16'h4000, 8'(8 + sel));
      v = win_rd_data;
   endtask

   task automatic set_reg(int sel, logic [7:0] d);
      cpu_wr(16'h4000, 8'(8 + sel));
      cpu_wr(16'hA000, d);
   endtask

   task automatic check_time(string rq);
      logic [7:0] v;
      rd_reg(0, v); check({rq, " sec"}, v, m_s);
      rd_reg(1, v); check({rq, " min"}, v, m_m);
      rd_reg(2, v); check({rq, " hour"}, v, m_h);
      rd_reg(3, v); check({rq, " R7 day_lo"}, v, m_d & 8'hFF);
      rd_reg(4, v); check({rq, " R7/R8 day_hi"}, v, (m_c << 7) | (m_d >> 8));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, v0;
      int exp_en, exp_bank, exp_acc, exp_rom;
      int steps[8] = '{1, 58, 1, 600, 2939, 82800, 100, 3600};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 rom_bank", rom_bank, 1);
      check("R11 ram_bank", ram_bank, 0);
      check("R11 ram_en", ram_en, 0);
      check("R11 rtc_sel", rtc_sel, 0);
      check("R11 win_rd_data", win_rd_data, 8'hFF);

      // R1 sweep of region 0
      exp_en = 0;
      for (int x = 0; x < 256; x++) begin
         cpu_wr(16'h0000 | 16'(x << 3), 8'(x));
         if (x == 8'h0A) exp_en = 1; else if (x == 0) exp_en = 0;
         check("R1 ram_en", ram_en, exp_en);
      end
      cpu_wr(16'h2000, 8'h00);
      cpu_wr(16'h4000, 8'h00);
      check("R1 other region keeps ram_en", ram_en, 1);

      // R2 sweep of region 1
      for (int x = 0; x < 256; x++) begin
         cpu_wr(16'h2000 | 16'(x << 4), 8'(x));
         exp_rom = x & 8'h7F;
         if (exp_rom == 0) exp_rom = 1;
         check("R2 rom_bank", rom_bank, exp_rom);
      end

      // R3 sweep of region 2 (window enabled)
      exp_bank = 0; exp_acc = 0;
      for (int x = 0; x < 256; x++) begin
         cpu_wr(16'h4000, 8'(x));
         if (x < 4) begin exp_bank = x; exp_acc = 0; end
         else if (x >= 8 && x <= 12) exp_acc = 1;
         check("R3 ram_bank", ram_bank, exp_bank);
         check("R3 rtc_sel", rtc_sel, exp_acc);
         check("R9 ram_sel", ram_sel, exp_acc == 0 ? 1 : 0);
      end

      // R9 window closed / RAM selected reads 0xFF
      cpu_wr(16'h4000, 8'h01);
      check("R9 ram selected", win_rd_data, 8'hFF);
      cpu_wr(16'h4000, 8'h08);
      cpu_wr(16'h0000, 8'h00);
      check("R9 window disabled", win_rd_data, 8'hFF);
      cpu_wr(16'h0000, 8'h0A);

      // R6 / R4 tick runs checked at latch points
      foreach (steps[k]) begin
         run_ticks(steps[k]);
         do_latch();
         check_time("R6 R4");
      end

      // R5 frozen snapshot, R4 repeated 1 ignored
      rd_reg(0, v0);
      run_ticks(10);
      rd_reg(0, v);
      check("R5 frozen after ticks", v, v0);
      cpu_wr(16'h6000, 8'h01);
      rd_reg(0, v);
      check("R4 second 1 ignored", v, v0);
      cpu_wr(16'h6000, 8'h05);
      cpu_wr(16'h6000, 8'h01);
      rd_reg(0, v);
      check("R4 other value ignored", v, v0);
      do_latch();
      rd_reg(0, v);
      check("R4 relatch updates", v, m_s);

      // R10 preset to overflow point, R8 carry set
      set_reg(2, 8'd23); m_h = 23;
      set_reg(1, 8'd59); m_m = 59;
      set_reg(0, 8'd59); m_s = 59;
      set_reg(3, 8'hFF);
      set_reg(4, 8'h01); m_d = 511; m_c = 0;
      do_latch();
      check_time("R10 preset");
      run_ticks(1);
      do_latch();
      check_time("R8 overflow");
      check("R8 carry model", m_c, 1);

      // R8 sticky through a second overflow
      set_reg(2, 8'd23); set_reg(1, 8'd59); set_reg(0, 8'd59);
      set_reg(3, 8'hFF); set_reg(4, 8'h81);
      m_h = 23; m_m = 59; m_s = 59; m_d = 511;
      run_ticks(1);
      do_latch();
      check_time("R8 sticky");

      // R8 clear by write, R7 day layout
      set_reg(4, 8'h01); set_reg(3, 8'h2A);
      m_c = 0; m_d = 9'h12A;
      do_latch();
      check_time("R8 clear R7 layout");

      // R10 write wins over simultaneous tick
      cpu_wr(16'h4000, 8'h08);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'hA000; wr_data = 8'd5; sec_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; sec_tick = 1'b0;
      m_s = 5;
      do_latch();
      check_time("R10 precedence");

      // R10 write ignored when clock access off
      cpu_wr(16'h4000, 8'h00);
      cpu_wr(16'hA000, 8'h11);
      do_latch();
      rd_reg(0, v);
      check("R10 ignored when RAM selected", v, m_s);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule